// File: doc/BRIEF.md
# Monitor Channel Handshake

This block moves maintenance bytes across a framed time-division serial bus, one byte per direction per frame. In both directions a byte travels together with two active-low handshake bits: MX, with which the sender marks the byte as valid, and MR, with which the receiver acknowledges it. The two bits are carried in the frame's command/indication byte, not inside the monitor byte. A frame-sync strobe marks each frame boundary. All bus-facing outputs update at that boundary, and all bus-facing inputs are sampled there.

The transmit side accepts a byte from a local valid/ready port. It places the byte on the outgoing monitor slot with MX low and repeats it in every frame until the peer pulls MR low. It then returns MX high for at least one frame before the next byte goes out. The receive side watches the incoming MX. On a high-to-low transition it latches the incoming byte, reports it once on a one-cycle local strobe, and drives MR low. It holds MR low until the sender lets MX rise. Bits therefore follow the frame clock, while bytes advance only as fast as the handshake allows.

Top module: `monitorHandshake`

## Requirements
- R1: Out of reset the block drives outgoing MX = 1, outgoing MR = 1 and an all-ones outgoing monitor byte, asserts sendReady = 1 and holds recvValid = 0.
- R2: The outgoing MX, MR and monitor byte change only at a clock edge where frameSync is 1. Bus inputs are ignored in cycles without frameSync.
- R3: A byte is accepted when sendValid and sendReady are both 1 at a clock edge. sendReady is 1 only while no byte is outstanding and outgoing MX is 1.
- R4: At the first frameSync edge after acceptance, the outgoing byte becomes the accepted value and outgoing MX becomes 0.
- R5: While incoming MR is sampled as 1 at frameSync, the same byte and MX = 0 are presented again in every frame.
- R6: A frameSync edge that samples incoming MR = 0 while a byte is presented sets outgoing MX to 1 and the outgoing byte to all ones, and sendReady returns to 1.
- R7: After an acknowledge, outgoing MX stays 1 for at least one full frame before it goes to 0 for the next byte.
- R8: A frameSync edge that samples incoming MX = 0, when the previous sample was 1 (reset counts as 1), latches the incoming byte. recvValid is then 1 for exactly one cycle with recvData equal to that byte, and outgoing MR goes to 0.
- R9: Later frames with incoming MX still 0 produce no further recvValid, leave recvData unchanged even if the incoming byte differs, and keep outgoing MR at 0.
- R10: A frameSync edge that samples incoming MX = 1 sets outgoing MR to 1.
- R11: With the bus outputs looped back to the inputs, a stream of bytes offered on the send port arrives on the receive port complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | One-cycle strobe marking a bus frame boundary |
| sendData | input | MON_W | Byte offered for transmission |
| sendValid | input | 1 | sendData is valid |
| sendReady | output | 1 | Block can accept a byte |
| recvData | output | MON_W | Last received byte |
| recvValid | output | 1 | One-cycle strobe for a newly received byte |
| busOutByte | output | MON_W | Outgoing monitor byte slot |
| busOutMx | output | 1 | Outgoing MX, active low: our byte is valid |
| busOutMr | output | 1 | Outgoing MR, active low: peer's byte is acknowledged |
| busInByte | input | MON_W | Incoming monitor byte slot |
| busInMx | input | 1 | Incoming MX from the peer sender |
| busInMr | input | 1 | Incoming MR from the peer receiver |

## Verification
The bench pulls MR low between frame boundaries. A design that sampled asynchronously would take this as an acknowledge and drop a byte the peer never read. It then holds incoming MX low over several frames while the byte underneath changes. A receiver that detected levels instead of the high-to-low edge would report duplicates or overwrite recvData. Right after an acknowledge, a new byte is offered at once, to catch a transmitter that skips the mandatory MX-high frame and so merges two bytes into one continuous low. A loopback run then checks that the handshake paces a whole byte stream without losses or reordering.

// File: rtl/monHsPkg.sv
package monHsPkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARMED = 2'd1,
    TX_SEND  = 2'd2
  } txState_e;

  // Strobes from the control FSMs to the byte registers
  typedef struct packed {
    logic loadHold;     // take sendData into the holding register
    logic presentByte;  // drive held byte onto the outgoing slot
    logic releaseByte;  // return outgoing slot to all ones
    logic captureRx;    // latch incoming slot into recvData
  } dpCtrl_t;

endpackage

// File: rtl/monHsCtrl.sv
module monHsCtrl
  import monHsPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameSync,
  input  logic    sendValid,
  input  logic    busInMx,
  input  logic    busInMr,
  output dpCtrl_t ctrl,
  output logic    busOutMx,
  output logic    busOutMr,
  output logic    sendReady,
  output logic    recvValid
);

  txState_e txState, txNext;
  logic     mxPrevSample;
  logic     mxEdge;

  // Receive side: a new byte is a high-to-low MX seen across two frame samples
  assign mxEdge = frameSync && !busInMx && mxPrevSample;

  always_comb begin
    ctrl   = '0;
    txNext = txState;
    unique case (txState)
      TX_IDLE: begin
        if (sendValid) begin
          ctrl.loadHold = 1'b1;
          txNext        = TX_ARMED;
        end
      end
      TX_ARMED: begin
        if (frameSync) begin
          ctrl.presentByte = 1'b1;
          txNext           = TX_SEND;
        end
      end
      TX_SEND: begin
        if (frameSync && !busInMr) begin
          ctrl.releaseByte = 1'b1;
          txNext           = TX_IDLE;
        end
      end
      default: txNext = TX_IDLE;
    endcase
    ctrl.captureRx = mxEdge;
  end

  assign sendReady = (txState == TX_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState      <= TX_IDLE;
      busOutMx     <= 1'b1;
      busOutMr     <= 1'b1;
      mxPrevSample <= 1'b1;
      recvValid    <= 1'b0;
    end else begin
      txState   <= txNext;
      recvValid <= mxEdge;
      if (ctrl.presentByte)      busOutMx <= 1'b0;
      else if (ctrl.releaseByte) busOutMx <= 1'b1;
      if (frameSync) begin
        mxPrevSample <= busInMx;
        if (busInMx)     busOutMr <= 1'b1;
        else if (mxEdge) busOutMr <= 1'b0;
      end
    end
  end

  p_mx_frame_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameSync |=> $stable(busOutMx));

  p_mr_frame_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameSync |=> $stable(busOutMr));

  p_ready_only_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    sendReady |-> busOutMx);

  p_release_on_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOutMx) |-> $past(frameSync && !busInMr));

  p_ack_with_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    recvValid |-> !busOutMr);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    recvValid |=> !recvValid);

  p_mr_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && busInMx) |=> busOutMr);

endmodule

// File: rtl/monHsDatapath.sv
module monHsDatapath
  import monHsPkg::*;
#(
  parameter int MON_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic [MON_W-1:0] sendData,
  input  logic [MON_W-1:0] busInByte,
  output logic [MON_W-1:0] busOutByte,
  output logic [MON_W-1:0] recvData
);

  localparam logic [MON_W-1:0] IDLE_FILL = {MON_W{1'b1}};

  logic [MON_W-1:0] holdByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte   <= IDLE_FILL;
      busOutByte <= IDLE_FILL;
      recvData   <= '0;
    end else begin
      if (ctrl.loadHold)         holdByte   <= sendData;
      if (ctrl.presentByte)      busOutByte <= holdByte;
      else if (ctrl.releaseByte) busOutByte <= IDLE_FILL;
      if (ctrl.captureRx)        recvData   <= busInByte;
    end
  end

  p_capture_value_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.captureRx |=> (recvData == $past(busInByte)));

  p_hold_rx_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.captureRx |=> $stable(recvData));

endmodule

// File: rtl/monitorHandshake.sv
module monitorHandshake
  import monHsPkg::*;
#(
  parameter int MON_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSync,
  input  logic [MON_W-1:0] sendData,
  input  logic             sendValid,
  output logic             sendReady,
  output logic [MON_W-1:0] recvData,
  output logic             recvValid,
  output logic [MON_W-1:0] busOutByte,
  output logic             busOutMx,
  output logic             busOutMr,
  input  logic [MON_W-1:0] busInByte,
  input  logic             busInMx,
  input  logic             busInMr
);

  dpCtrl_t ctrl;

  monHsCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .sendValid (sendValid),
    .busInMx   (busInMx),
    .busInMr   (busInMr),
    .ctrl      (ctrl),
    .busOutMx  (busOutMx),
    .busOutMr  (busOutMr),
    .sendReady (sendReady),
    .recvValid (recvValid)
  );

  monHsDatapath #(.MON_W(MON_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .sendData   (sendData),
    .busInByte  (busInByte),
    .busOutByte (busOutByte),
    .recvData   (recvData)
  );

  p_idle_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    busOutMx |-> (busOutByte == {MON_W{1'b1}}));

  p_repeat_same_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busOutMx && $past(!busOutMx)) |-> $stable(busOutByte));

  p_byte_frame_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameSync |=> $stable(busOutByte));

endmodule

// File: tb/tb_monitorHandshake.sv
`timescale 1ns/1ps
module tb_monitorHandshake;

  localparam int W = 8;
  localparam int FRAME_GAP = 5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         fs = 1'b0;
  logic [W-1:0] sendData = '0;
  logic         sendValid = 1'b0;
  logic         sendReady, recvValid, busOutMx, busOutMr;
  logic [W-1:0] recvData, busOutByte;
  logic [W-1:0] drvByte = '1;
  logic         drvMx = 1'b1, drvMr = 1'b1, loopMode = 1'b0;
  logic [W-1:0] busInByte;
  logic         busInMx, busInMr;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [W-1:0] gotQ [8];
  int gotCnt = 0;

  always #4 clk = ~clk;

  assign busInByte = loopMode ? busOutByte : drvByte;
  assign busInMx   = loopMode ? busOutMx   : drvMx;
  assign busInMr   = loopMode ? busOutMr   : drvMr;

  monitorHandshake #(.MON_W(W)) dut (
    .clk(clk), .rstN(rstN), .frameSync(fs),
    .sendData(sendData), .sendValid(sendValid), .sendReady(sendReady),
    .recvData(recvData), .recvValid(recvValid),
    .busOutByte(busOutByte), .busOutMx(busOutMx), .busOutMr(busOutMr),
    .busInByte(busInByte), .busInMx(busInMx), .busInMr(busInMr)
  );

  always @(negedge clk) begin
    if (loopMode && recvValid && gotCnt < 8) begin
      gotQ[gotCnt] = recvData;
      gotCnt++;
    end
  end

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic frameEdge();
    @(negedge clk) fs = 1'b1;
    @(negedge clk) fs = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge clk);
    sendData  = d;
    sendValid = 1'b1;
    @(negedge clk) sendValid = 1'b0;
  endtask

  task automatic tReset();
    chkEq("R1", "MX", busOutMx, 1);
    chkEq("R1", "MR", busOutMr, 1);
    chkEq("R1", "byte", busOutByte, 8'hFF);
    chkEq("R1", "ready", sendReady, 1);
    chkEq("R1", "recvValid", recvValid, 0);
  endtask

  task automatic tTransmit();
    drvMr = 1'b1;
    push(8'hA5);
    chkEq("R3", "ready after accept", sendReady, 0);
    idle(2);
    chkEq("R2", "MX before frame edge", busOutMx, 1);
    frameEdge();
    chkEq("R4", "MX presented", busOutMx, 0);
    chkEq("R4", "byte presented", busOutByte, 8'hA5);
    idle(FRAME_GAP);
    for (int i = 0; i < 2; i++) begin
      frameEdge();
      chkEq("R5", "MX repeat", busOutMx, 0);
      chkEq("R5", "byte repeat", busOutByte, 8'hA5);
      idle(FRAME_GAP);
    end
    // MR low between frame boundaries must not count as an acknowledge
    @(negedge clk) drvMr = 1'b0;
    idle(2);
    drvMr = 1'b1;
    frameEdge();
    chkEq("R2", "off-frame MR ignored", busOutMx, 0);
    chkEq("R3", "ready while outstanding", sendReady, 0);
    idle(FRAME_GAP);
    drvMr = 1'b0;
    frameEdge();
    chkEq("R6", "MX released", busOutMx, 1);
    chkEq("R6", "byte all ones", busOutByte, 8'hFF);
    chkEq("R6", "ready back", sendReady, 1);
    push(8'h3C);
    idle(2);
    chkEq("R7", "MX high during gap frame", busOutMx, 1);
    drvMr = 1'b1;
    frameEdge();
    chkEq("R7", "next byte after gap", busOutMx, 0);
    chkEq("R7", "next byte value", busOutByte, 8'h3C);
    idle(FRAME_GAP);
    drvMr = 1'b0;
    frameEdge();
    chkEq("R6", "second ack", busOutMx, 1);
    drvMr = 1'b1;
    idle(FRAME_GAP);
  endtask

  task automatic tReceive();
    drvMx = 1'b1; drvByte = 8'hFF;
    frameEdge();
    chkEq("R10", "MR idle", busOutMr, 1);
    chkEq("R8", "no valid while MX high", recvValid, 0);
    idle(FRAME_GAP);
    @(negedge clk); drvMx = 1'b0; drvByte = 8'h5A;
    frameEdge();
    chkEq("R8", "valid pulse", recvValid, 1);
    chkEq("R8", "data", recvData, 8'h5A);
    chkEq("R8", "MR low", busOutMr, 0);
    @(negedge clk);
    chkEq("R8", "pulse one cycle", recvValid, 0);
    idle(FRAME_GAP - 1);
    drvByte = 8'h77;
    for (int i = 0; i < 2; i++) begin
      frameEdge();
      chkEq("R9", "no repeat valid", recvValid, 0);
      chkEq("R9", "data held", recvData, 8'h5A);
      chkEq("R9", "MR held low", busOutMr, 0);
      idle(FRAME_GAP);
    end
    drvMx = 1'b1;
    frameEdge();
    chkEq("R10", "MR released", busOutMr, 1);
    chkEq("R10", "no valid on release", recvValid, 0);
    idle(FRAME_GAP);
    drvMx = 1'b0;
    frameEdge();
    chkEq("R8", "second byte valid", recvValid, 1);
    chkEq("R8", "second byte data", recvData, 8'h77);
    idle(FRAME_GAP);
    drvMx = 1'b1;
    frameEdge();
    idle(FRAME_GAP);
  endtask

  task automatic tLoopback();
    logic [W-1:0] stream [4];
    stream[0] = 8'h11; stream[1] = 8'hE2; stream[2] = 8'h00; stream[3] = 8'h9F;
    gotCnt = 0;
    loopMode = 1'b1;
    for (int b = 0; b < 4; b++) begin
      push(stream[b]);
      for (int f = 0; f < 12 && !sendReady; f++) begin
        frameEdge();
        idle(FRAME_GAP);
      end
    end
    for (int f = 0; f < 4; f++) begin
      frameEdge();
      idle(FRAME_GAP);
    end
    chkEq("R11", "loop byte count", gotCnt, 4);
    for (int b = 0; b < 4; b++)
      chkEq("R11", "loop byte order", (b < gotCnt) ? int'(gotQ[b]) : -1, stream[b]);
    loopMode = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tTransmit();
    tReceive();
    tLoopback();
    summary();
    $finish;
  end

endmodule